// File: doc/BRIEF.md
# Multi-Channel Gain-Settling Qualifier

This block decides when a low-power receiver may wake on a new input. It watches several signal-present lines, one per receive channel. Whenever a channel's line goes high from idle, that channel starts its own settling timer. While the analog gain loop settles, the downstream output-enable filter is kept in reset. A channel qualifies only if its line stays high on every clock sample of the window, including the sample at the very end. If the line drops at any point, that channel's attempt is abandoned, a one-cycle soft-reset pulse is issued, and a fresh high input is needed to start a new full window.

The block is controlled by a sequencer with three states. In `TOP_SLEEP` no channel is timing. In `TOP_SETTLE` at least one channel is counting. In `TOP_AWAKE` the rest of the receiver runs. The named transitions are:
- `SLEEP->SETTLE`: some idle channel sees its line high.
- `SETTLE->AWAKE`: some channel completes its window.
- `SETTLE->SLEEP`: every counting channel has aborted and nothing new has started.
- `AWAKE->SLEEP`: all lines are seen low together.

Each channel timer has two states, `CH_IDLE` and `CH_COUNT`. The transitions are `IDLE->COUNT` on a high line, `COUNT->IDLE` on completion or on a break, and a forced return to idle while the receiver is awake.

A sticky wake-source field records which channels completed on the edge that woke the receiver. If several channels complete on that same edge, all of their bits are set. The field is cleared only by the status-clear input. The window length is set by `SETTLE_TICKS` (default 112 ticks of the 32 kHz clock, about 3.5 ms).

Top module: `agc_settle_qualifier`

## Requirements
- R1: While reset is asserted and right after it, filter_hold is 1, wake is 0, soft_rst is 0 and wake_src is 000.
- R2: filter_hold is 1 while the receiver is asleep and during every settling window. It is 0 exactly in the cycles where wake is 1.
- R3: A channel i that starts from idle completes when sig_present[i] is sampled high on SETTLE_TICKS+1 consecutive rising edges. wake becomes 1 in the cycle after the last of those edges, and not earlier.
- R4: If sig_present[i] is sampled low on any later edge of the window, including the final one, then channel i returns to idle, soft_rst is 1 for the cycle after that edge, and no wake results. A new high input then needs a full new window.
- R5: While wake is 1 it stays 1 as long as any sig_present line is high. After an edge that samples all lines low, wake is 0 and filter_hold is 1.
- R6: On the waking edge, wake_src bit i (bit 0 is channel 0) is set for every channel that completes on that edge. Simultaneous completions set several bits.
- R7: While the receiver is awake, all channel timers are held idle. A channel that would complete later sets no wake_src bit and causes no soft_rst.
- R8: wake_src bits stay set across sleep and later wakes, where new bits are ORed in. Only a status_clr sampled high clears them. A completion on the same edge as a clear leaves exactly the new bits.
- R9: Each channel has its own counter. A break on one channel does not restart or delay the count of another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz timing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sig_present | input | NUM_CH | Per-channel signal-present lines |
| status_clr | input | 1 | Clears the wake-source field |
| filter_hold | output | 1 | Holds the output-enable filter in reset |
| wake | output | 1 | Wakes the rest of the receiver |
| soft_rst | output | 1 | One-cycle pulse on an aborted window |
| wake_src | output | NUM_CH | Sticky record of the channels that woke the receiver |

## Verification
The bench checks the exact cycle of completion. It also checks a line that drops on the very last sample of the window: a design that skips the end-of-window check would wake there instead of pulsing soft_rst. It checks a restart after a break, which catches a counter that is not cleared and wakes too early. It checks staggered channels, which catches a design that lets a late channel set its wake bit after the receiver is already awake. It also checks simultaneous completions and a clear that lands on the same edge as a completion, which expose lost or stale wake-source bits. Finally, it aborts one channel while another is counting, so a shared or cross-reset counter would show up as a late wake.

// File: rtl/agc_settle_pkg.sv
package agc_settle_pkg;

    typedef enum logic [1:0] {
        TOP_SLEEP  = 2'd0,
        TOP_SETTLE = 2'd1,
        TOP_AWAKE  = 2'd2
    } top_state_e;

    typedef enum logic {
        CH_IDLE  = 1'b0,
        CH_COUNT = 1'b1
    } ch_state_e;

endpackage

// File: rtl/agc_ch_timer.sv
module agc_ch_timer
    import agc_settle_pkg::*;
#(
    parameter int unsigned SETTLE_TICKS = 112
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic sig,
    output logic start,
    output logic counting,
    output logic done,
    output logic abort
);

    localparam int unsigned CW = (SETTLE_TICKS > 1) ? $clog2(SETTLE_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE_TICKS - 1);

    ch_state_e      state_q, state_d;
    logic [CW-1:0]  cnt_q;

    // Per-channel events, decoded from the current state and the line
    always_comb begin
        start    = (state_q == CH_IDLE) && sig && !flush;
        counting = (state_q == CH_COUNT);
        done     = counting && !flush && sig && (cnt_q == LAST);
        abort    = counting && !flush && !sig;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE:  if (start) state_d = CH_COUNT;
            CH_COUNT: if (flush || done || abort) state_d = CH_IDLE;
            default:  state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == CH_COUNT && state_q == CH_COUNT)
                cnt_q <= cnt_q + 1'b1;
            else
                cnt_q <= '0;
        end
    end

endmodule

// File: rtl/agc_wake_seq.sv
module agc_wake_seq
    import agc_settle_pkg::*;
#(
    parameter int unsigned NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] sig_present,
    input  logic [NUM_CH-1:0] start,
    input  logic [NUM_CH-1:0] counting,
    input  logic [NUM_CH-1:0] done,
    input  logic [NUM_CH-1:0] abort,
    output logic              filter_hold,
    output logic              wake,
    output logic              flush,
    output logic              soft_rst
);

    top_state_e state_q, state_d;
    logic       soft_q;
    logic       busy_next;

    always_comb begin
        busy_next = (|(counting & ~abort & ~done)) | (|start);
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TOP_SLEEP:  if (|start) state_d = TOP_SETTLE;
            TOP_SETTLE: begin
                if (|done)           state_d = TOP_AWAKE;
                else if (!busy_next) state_d = TOP_SLEEP;
            end
            TOP_AWAKE:  if (sig_present == '0) state_d = TOP_SLEEP;
            default:    state_d = TOP_SLEEP;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TOP_SLEEP;
            soft_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            soft_q  <= |abort;
        end
    end

    // Outputs
    always_comb begin
        filter_hold = 1'b1;
        wake        = 1'b0;
        flush       = 1'b0;
        unique case (state_q)
            TOP_SLEEP, TOP_SETTLE: begin
                filter_hold = 1'b1;
            end
            TOP_AWAKE: begin
                filter_hold = 1'b0;
                wake        = 1'b1;
                flush       = 1'b1;
            end
            default: ;
        endcase
        soft_rst = soft_q;
    end

endmodule

// File: rtl/agc_wake_src_reg.sv
module agc_wake_src_reg #(
    parameter int unsigned NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [NUM_CH-1:0] set_bits,
    output logic [NUM_CH-1:0] src
);

    // A clear drops old bits; bits set on the same edge survive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src <= '0;
        else        src <= (clr ? '0 : src) | set_bits;
    end

endmodule

// File: rtl/agc_settle_qualifier.sv
module agc_settle_qualifier #(
    parameter int unsigned NUM_CH       = 3,
    parameter int unsigned SETTLE_TICKS = 112
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] sig_present,
    input  logic              status_clr,
    output logic              filter_hold,
    output logic              wake,
    output logic              soft_rst,
    output logic [NUM_CH-1:0] wake_src
);

    logic [NUM_CH-1:0] ch_start, ch_counting, ch_done, ch_abort;
    logic              flush;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        agc_ch_timer #(.SETTLE_TICKS(SETTLE_TICKS)) i_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .sig      (sig_present[g]),
            .start    (ch_start[g]),
            .counting (ch_counting[g]),
            .done     (ch_done[g]),
            .abort    (ch_abort[g])
        );
    end

    agc_wake_seq #(.NUM_CH(NUM_CH)) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .sig_present (sig_present),
        .start       (ch_start),
        .counting    (ch_counting),
        .done        (ch_done),
        .abort       (ch_abort),
        .filter_hold (filter_hold),
        .wake        (wake),
        .flush       (flush),
        .soft_rst    (soft_rst)
    );

    agc_wake_src_reg #(.NUM_CH(NUM_CH)) i_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (status_clr),
        .set_bits (ch_done),
        .src      (wake_src)
    );

endmodule

// File: rtl/agc_settle_checker.sv
module agc_settle_checker #(
    parameter int unsigned NUM_CH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] sig_present,
    input logic              status_clr,
    input logic              filter_hold,
    input logic              wake,
    input logic              soft_rst,
    input logic [NUM_CH-1:0] wake_src
);

    AST_HOLD_WHEN_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> !filter_hold); // R2

    AST_SRC_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake) |-> (wake_src != '0)); // R6

    AST_SRC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !status_clr |=> ((wake_src & $past(wake_src)) == $past(wake_src))); // R8

    AST_SRC_ONLY_AT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ((wake_src & ~$past(wake_src)) != '0) |-> $rose(wake)); // R7

    AST_QUIET_WHILE_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && $past(wake)) |-> !soft_rst); // R7

    AST_SLEEP_ON_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && sig_present == '0) |=> !wake); // R5

endmodule

bind agc_settle_qualifier agc_settle_checker #(.NUM_CH(NUM_CH)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sig_present (sig_present),
    .status_clr  (status_clr),
    .filter_hold (filter_hold),
    .wake        (wake),
    .soft_rst    (soft_rst),
    .wake_src    (wake_src)
);

// File: tb/test_agc_settle_qualifier.sv
module test_agc_settle_qualifier;

    localparam int N = 112;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sig = 3'b000;
    logic       clr = 1'b0;
    logic       filter_hold, wake, soft_rst;
    logic [2:0] wake_src;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit wake_d = 1'b0;

    typedef struct {
        bit         is_wake;
        logic [2:0] src;
        int         at;
        string      req;
    } ev_t;

    ev_t exp_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    agc_settle_qualifier i_agc_settle_qualifier (
        .clk         (clk),
        .rst_n       (rst_n),
        .sig_present (sig),
        .status_clr  (clr),
        .filter_hold (filter_hold),
        .wake        (wake),
        .soft_rst    (soft_rst),
        .wake_src    (wake_src)
    );

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input bit w, input logic [2:0] s, input int at, input string req);
        ev_t e;
        e.is_wake = w; e.src = s; e.at = at; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic match(input bit w, input logic [2:0] s);
        ev_t e;
        n_cmp++;
        if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL unexpected %s event at cycle %0d: actual src %0h expected none",
                     w ? "wake" : "soft_rst", cyc, s);
        end else begin
            e = exp_q.pop_front();
            if (e.is_wake !== w || e.at != cyc || (w && e.src !== s)) begin
                n_bad++;
                $display("FAIL %s event: actual kind %0d cycle %0d src %0h expected kind %0d cycle %0d src %0h",
                         e.req, w, cyc, s, e.is_wake, e.at, e.src);
            end
        end
    endtask

    // Monitor: compares observed wake and soft-reset events with the queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (soft_rst) match(1'b0, 3'b000);
            if (wake && !wake_d) match(1'b1, wake_src);
            wake_d = wake;
        end
    end

    task automatic wait_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        chk("R1", "filter_hold in reset", filter_hold, 1);
        chk("R1", "wake in reset", wake, 0);
        chk("R1", "soft_rst in reset", soft_rst, 0);
        chk("R1", "wake_src in reset", wake_src, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "wake_src after reset", wake_src, 0);

        // R3: single channel completes a full window
        c = cyc; sig[0] = 1'b1;
        push(1'b1, 3'b001, c + 1 + N, "R3");
        wait_cyc(c + N / 2);
        chk("R2", "filter_hold mid window", filter_hold, 1);
        wait_cyc(c + N);
        chk("R3", "wake before last sample", wake, 0);
        @(negedge clk);
        chk("R3", "wake after window", wake, 1);
        chk("R2", "filter_hold released", filter_hold, 0);
        chk("R6", "wake_src single", wake_src, 3'b001);

        // R5 / R8: silence returns to sleep, bits stay
        repeat (3) @(negedge clk);
        chk("R5", "wake held while line high", wake, 1);
        sig = 3'b000;
        @(negedge clk);
        chk("R5", "wake after silence", wake, 0);
        chk("R5", "filter_hold after silence", filter_hold, 1);
        chk("R8", "wake_src sticky in sleep", wake_src, 3'b001);
        pulse_clr();
        chk("R8", "wake_src cleared", wake_src, 3'b000);

        // R4: break in the middle, then full restart
        c = cyc; sig[1] = 1'b1;
        wait_cyc(c + 40);
        sig[1] = 1'b0;
        push(1'b0, 3'b000, c + 41, "R4");
        repeat (3) @(negedge clk);
        chk("R4", "no wake after break", wake, 0);
        c = cyc; sig[1] = 1'b1;
        push(1'b1, 3'b010, c + 1 + N, "R4");
        wait_cyc(c + N);
        chk("R4", "restart needs full window", wake, 0);
        @(negedge clk);
        chk("R4", "wake after restart", wake, 1);
        sig = 3'b000;
        @(negedge clk);
        pulse_clr();

        // R4: line lost on the final sample of the window
        c = cyc; sig[2] = 1'b1;
        wait_cyc(c + N);
        sig[2] = 1'b0;
        push(1'b0, 3'b000, c + N + 1, "R4");
        repeat (3) @(negedge clk);
        chk("R4", "no wake on end-of-window drop", wake, 0);
        chk("R4", "wake_src after end drop", wake_src, 3'b000);

        // R6: simultaneous completion on two channels
        c = cyc; sig = 3'b101;
        push(1'b1, 3'b101, c + 1 + N, "R6");
        wait_cyc(c + N + 2);
        chk("R6", "wake_src simultaneous", wake_src, 3'b101);
        sig = 3'b000;
        @(negedge clk);
        pulse_clr();

        // R7 / R9: staggered channels, one aborts while others count
        c = cyc; sig[1] = 1'b1;
        wait_cyc(c + 10); sig[2] = 1'b1;
        wait_cyc(c + 20); sig[0] = 1'b1;
        wait_cyc(c + 30); sig[0] = 1'b0;
        push(1'b0, 3'b000, c + 31, "R9");
        push(1'b1, 3'b010, c + 1 + N, "R9");
        wait_cyc(c + 10 + N + 6);
        chk("R7", "late channel sets no bit", wake_src, 3'b010);
        chk("R7", "still awake", wake, 1);
        sig = 3'b000;
        @(negedge clk);

        // R8: new wake ORs into the existing bits
        c = cyc; sig[0] = 1'b1;
        push(1'b1, 3'b011, c + 1 + N, "R8");
        wait_cyc(c + N + 2);
        chk("R8", "bits accumulate", wake_src, 3'b011);
        sig = 3'b000;
        @(negedge clk);

        // R8: clear on the same edge as a completion
        c = cyc; sig[2] = 1'b1;
        push(1'b1, 3'b100, c + 1 + N, "R8");
        wait_cyc(c + N);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R8", "clear with completion", wake_src, 3'b100);
        sig = 3'b000;
        repeat (3) @(negedge clk);

        chk("R3", "all expected events seen", exp_q.size(), 0);
        report();
        $finish;
    end

endmodule